// File: doc/BRIEF.md
# Fan commutation fault supervisor

This block watches a PWM-driven brushless fan through its commutation pulses and decides, period by period, whether the fan is spinning. It gives the fan a full-drive kick at start-up. During normal running it keeps a missing-pulse watchdog. When that watchdog runs out, it escalates: first a short full-drive probe, then one more full-drive start-up attempt, and then a latched fan-fault state. It does not produce the PWM waveform itself. It tells the surrounding drive logic either to force the output fully on (`force_on`) or to let the proportional PWM run (`pwm_enable`). All time windows are counted in PWM periods, taken from a period strobe.

The fault output `fault_n` is active low. It reports the latched fan fault and also passes on a non-latching over-temperature flag. The shutdown input is a level. While it is high it stops the drive and releases the fault output. When it is released, the sequence restarts exactly as after power-up. The fan-fault latch is cleared only by reset or by a shutdown level held for a minimum number of clocks. Sense edges that arrive just after each PWM turn-on strobe are blanked, because switching noise would otherwise look like commutation.

States:
- HALT: shutdown, or the state after reset.
- SPIN1: first start-up burst.
- SPIN2: second start-up burst.
- RUN: normal operation.
- PROBE: diagnostic burst.
- SPINR: start-up retry.
- LOCK: latched fan fault.

Transitions:
- HALT→SPIN1: shutdown released.
- SPIN1→RUN, SPIN2→RUN, PROBE→RUN, SPINR→RUN: a fan pulse is accepted.
- SPIN1→SPIN2: burst count reached.
- SPIN2→LOCK: burst count reached.
- RUN→PROBE: watchdog count reached.
- PROBE→SPINR: diagnostic count reached.
- SPINR→LOCK: burst count reached.
- any state except LOCK → HALT: shutdown level high.
- LOCK→HALT: shutdown held for the qualified width.

Top module: `fan_fault_supervisor`

## Requirements
- R1: On leaving reset or shutdown, `force_on` is 1 and `pwm_enable` is 0 for BURST_PERIODS (32) period strobes, unless a fan pulse is accepted first.
- R2: If the first burst ends without a fan pulse, a second burst of BURST_PERIODS strobes follows with `force_on` = 1. If that burst also ends without a pulse, the fan-fault state is entered.
- R3: In normal operation `pwm_enable` = 1 and `force_on` = 0. Every accepted fan pulse restarts the watchdog. The watchdog expires on the WDOG_PERIODS-th (32nd) period strobe with no accepted pulse.
- R4: On watchdog expiry `force_on` = 1 for DIAG_PERIODS (3) strobes. A fan pulse accepted in that window returns the block to normal operation.
- R5: If the diagnostic window ends without a pulse, a retry burst of BURST_PERIODS strobes follows with `force_on` = 1. A pulse in the retry returns the block to normal operation. No pulse in the retry enters fan fault.
- R6: In fan fault, `fault_n` = 0, `force_on` = 0 and `pwm_enable` = 0, and the state persists indefinitely.
- R7: A sense rising edge whose synchronized copy reaches the edge detector within BLANK_CLKS (4) clocks after a `pwm_on_tick` strobe is not accepted as a fan pulse.
- R8: While `shutdown_in` = 1, the outputs are `force_on` = 0, `pwm_enable` = 0 and `fault_n` = 1, whatever the state or over-temperature flag. Releasing shutdown from any non-fault state restarts at the first start-up burst.
- R9: Fan fault is left only when `shutdown_in` stays high for at least SHDN_MIN_CLKS (6000) clocks. A shorter shutdown pulse leaves the fault latched after release.
- R10: When not in shutdown, `over_temp` = 1 drives `fault_n` to 0 and leaves the drive outputs unchanged. `fault_n` returns to 1 when the flag clears, unless fan fault holds it low.
- R11: Only rising edges of the sense input count as fan pulses. A sense level held high counts once.
- R12: During reset the outputs are `force_on` = 0, `pwm_enable` = 0 and `fault_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | One-clock strobe at each PWM period boundary |
| pwm_on_tick | input | 1 | One-clock strobe when the PWM output switches on |
| sense_in | input | 1 | Conditioned commutation pulse, asynchronous |
| shutdown_in | input | 1 | Shutdown level, active high, asynchronous |
| over_temp | input | 1 | Over-temperature flag, active high, asynchronous |
| force_on | output | 1 | Request to drive the fan fully on |
| pwm_enable | output | 1 | Permit for the proportional PWM drive |
| fault_n | output | 1 | Active-low fault: latched fan fault or over-temperature |

## Verification
The escalation is driven with a fan that never pulses from power-up. It is also driven with one that pulses once and then stops, sampled at many period offsets. This separates the lengths of the start-up, watchdog, diagnostic and retry windows, since an off-by-one in any of them moves the fault-entry period. Recovery pulses are placed inside the diagnostic window and inside the retry window, to show that each one returns the block to normal running. Pulses that land only inside the blanking window, and a sense line held high, must both let the watchdog expire. This tells true commutation apart from switching noise and from a stuck level. Short and long shutdown pulses, with and without over-temperature, separate the unconditional release of the fault output from the width-qualified clearing of the latch.

// File: rtl/fan_sup_pkg.sv
package fan_sup_pkg;

    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,
        ST_SPIN1 = 3'd1,
        ST_SPIN2 = 3'd2,
        ST_RUN   = 3'd3,
        ST_PROBE = 3'd4,
        ST_SPINR = 3'd5,
        ST_LOCK  = 3'd6
    } sup_state_t;

endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fs_edge_blank.sv
module fs_edge_blank #(
    parameter int BLANK_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_s,
    input  logic pwm_on_tick,
    output logic fan_pulse
);
    localparam int BW = $clog2(BLANK_CLKS + 1);

    logic          sense_q;
    logic [BW-1:0] blank_cnt;
    logic          blanking;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q   <= 1'b0;
            blank_cnt <= '0;
        end else begin
            sense_q <= sense_s;
            if (pwm_on_tick)
                blank_cnt <= BW'(BLANK_CLKS);
            else if (blank_cnt != '0)
                blank_cnt <= blank_cnt - 1'b1;
        end
    end

    assign blanking  = pwm_on_tick | (blank_cnt != '0);
    assign fan_pulse = sense_s & ~sense_q & ~blanking;

    // R7
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_on_tick |=> !fan_pulse);

    // R11
    level_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fan_pulse |=> !fan_pulse);
endmodule

// File: rtl/fs_shdn_qual.sv
module fs_shdn_qual #(
    parameter int MIN_CLKS = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_s,
    output logic shdn_long
);
    localparam int WW = $clog2(MIN_CLKS + 1);

    logic [WW-1:0] width_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            width_cnt <= '0;
        else if (!shdn_s)
            width_cnt <= '0;
        else if (width_cnt != WW'(MIN_CLKS))
            width_cnt <= width_cnt + 1'b1;
    end

    assign shdn_long = (width_cnt == WW'(MIN_CLKS));

    // R9
    long_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |=> !shdn_long);
endmodule

// File: rtl/fs_period_cnt.sv
module fs_period_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = tick & (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (done) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/fan_fault_supervisor.sv
module fan_fault_supervisor
    import fan_sup_pkg::*;
#(
    parameter int BURST_PERIODS = 32,
    parameter int WDOG_PERIODS  = 32,
    parameter int DIAG_PERIODS  = 3,
    parameter int BLANK_CLKS    = 4,
    parameter int SHDN_MIN_CLKS = 6000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_tick,
    input  logic pwm_on_tick,
    input  logic sense_in,
    input  logic shutdown_in,
    input  logic over_temp,
    output logic force_on,
    output logic pwm_enable,
    output logic fault_n
);
    localparam int MAX_AB = (BURST_PERIODS > WDOG_PERIODS) ? BURST_PERIODS : WDOG_PERIODS;
    localparam int MAX_P  = (MAX_AB > DIAG_PERIODS) ? MAX_AB : DIAG_PERIODS;
    localparam int CNT_W  = $clog2(MAX_P + 1);

    sup_state_t       state, state_n;
    logic             sense_s, shdn_s, ot_s;
    logic             fan_pulse, shdn_long;
    logic             win_done, win_clr;
    logic [CNT_W-1:0] win_limit;

    fs_sync #(.STAGES(SYNC_STAGES)) u_sync_sense (
        .clk(clk), .rst_n(rst_n), .d(sense_in), .q(sense_s));
    fs_sync #(.STAGES(SYNC_STAGES)) u_sync_shdn (
        .clk(clk), .rst_n(rst_n), .d(shutdown_in), .q(shdn_s));
    fs_sync #(.STAGES(SYNC_STAGES)) u_sync_ot (
        .clk(clk), .rst_n(rst_n), .d(over_temp), .q(ot_s));

    fs_edge_blank #(.BLANK_CLKS(BLANK_CLKS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sense_s(sense_s),
        .pwm_on_tick(pwm_on_tick), .fan_pulse(fan_pulse));

    fs_shdn_qual #(.MIN_CLKS(SHDN_MIN_CLKS)) u_shdn (
        .clk(clk), .rst_n(rst_n), .shdn_s(shdn_s), .shdn_long(shdn_long));

    fs_period_cnt #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .tick(period_tick),
        .limit(win_limit), .done(win_done));

    // Window length selected by the current state
    always_comb begin
        unique case (state)
            ST_RUN:   win_limit = CNT_W'(WDOG_PERIODS);
            ST_PROBE: win_limit = CNT_W'(DIAG_PERIODS);
            default:  win_limit = CNT_W'(BURST_PERIODS);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (shdn_s && state != ST_LOCK) begin
            state_n = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT:  state_n = ST_SPIN1;
                ST_SPIN1: if (fan_pulse) state_n = ST_RUN;
                          else if (win_done) state_n = ST_SPIN2;
                ST_SPIN2: if (fan_pulse) state_n = ST_RUN;
                          else if (win_done) state_n = ST_LOCK;
                ST_RUN:   if (!fan_pulse && win_done) state_n = ST_PROBE;
                ST_PROBE: if (fan_pulse) state_n = ST_RUN;
                          else if (win_done) state_n = ST_SPINR;
                ST_SPINR: if (fan_pulse) state_n = ST_RUN;
                          else if (win_done) state_n = ST_LOCK;
                ST_LOCK:  if (shdn_long) state_n = ST_HALT;
                default:  state_n = ST_HALT;
            endcase
        end
    end

    assign win_clr = (state_n != state) | (state == ST_RUN && fan_pulse)
                   | (state == ST_HALT) | (state == ST_LOCK);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_n;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_on   <= 1'b0;
            pwm_enable <= 1'b0;
            fault_n    <= 1'b1;
        end else if (shdn_s) begin
            force_on   <= 1'b0;
            pwm_enable <= 1'b0;
            fault_n    <= 1'b1;
        end else begin
            force_on   <= (state == ST_SPIN1) || (state == ST_SPIN2) ||
                          (state == ST_PROBE) || (state == ST_SPINR);
            pwm_enable <= (state == ST_RUN);
            fault_n    <= !((state == ST_LOCK) || ot_s);
        end
    end

    // R8
    shdn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s |=> (!force_on && !pwm_enable && fault_n));

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !shdn_long) |=> (state == ST_LOCK));

    // R6
    lock_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !shdn_s) |=> (!force_on && !pwm_enable && !fault_n));

    // R3
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({force_on, pwm_enable}));

    // R4
    probe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && $past(state) == ST_RUN) |-> $past(period_tick));

    // R10
    ot_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_s && !shdn_s) |=> !fault_n);
endmodule

// File: tb/tb_fan_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fan_fault_supervisor;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n, period_tick, pwm_on_tick, sense_in, shutdown_in, over_temp;
    logic force_on, pwm_enable, fault_n;
    int   tcnt;
    int   errs = 0;
    int   checks = 0;

    always #2.5 clk = ~clk;

    fan_fault_supervisor dut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .pwm_on_tick(pwm_on_tick), .sense_in(sense_in),
        .shutdown_in(shutdown_in), .over_temp(over_temp),
        .force_on(force_on), .pwm_enable(pwm_enable), .fault_n(fault_n));

    // Escalation table from one accepted pulse at period k:
    // periods after k, then expected {force_on, pwm_enable, fault_n}
    localparam int TAB_N [8] = '{1, 31, 32, 34, 35, 66, 67, 70};
    localparam logic [2:0] TAB_EXP [8] = '{3'b011, 3'b011, 3'b101, 3'b101,
                                           3'b101, 3'b101, 3'b000, 3'b000};
    // R3 R3 R4 R4 R5 R5 R5 R6
    localparam int TAB_R [8] = '{3, 3, 4, 4, 5, 5, 5, 6};

    // PWM period and turn-on strobes
    initial begin
        tcnt = 0; period_tick = 1'b0; pwm_on_tick = 1'b0;
        forever begin
            @(negedge clk);
            tcnt++;
            period_tick = (tcnt % P == 0);
            pwm_on_tick = (tcnt % P == 0);
        end
    end

    task automatic chk(input string req, input logic ef, input logic ep, input logic efn);
        checks++;
        if ({force_on, pwm_enable, fault_n} !== {ef, ep, efn}) begin
            errs++;
            $display("FAIL %s: actual force_on=%b pwm_enable=%b fault_n=%b expected %b %b %b",
                     req, force_on, pwm_enable, fault_n, ef, ep, efn);
        end
    endtask

    task automatic at_phase(input int ph);
        do @(posedge clk); while (tcnt % P != ph);
        #1;
    endtask

    task automatic at_period(input int pidx, input int ph);
        do @(posedge clk); while (!(tcnt / P == pidx && tcnt % P == ph));
        #1;
    endtask

    task automatic pulse();
        sense_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 sense_in = 1'b0;
    endtask

    task automatic long_shdn();
        shutdown_in = 1'b1;
        repeat (6100) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int base, k, k2, k3, k4;
        rst_n = 1'b0; sense_in = 1'b0; shutdown_in = 1'b0; over_temp = 1'b0;
        repeat (6) @(posedge clk);
        #1 chk("R12", 1'b0, 1'b0, 1'b1);

        // Power-up with a dead fan: two bursts, then fault
        at_phase(8);
        rst_n = 1'b1;
        base = tcnt / P;
        at_period(base + 1, 8);  chk("R1", 1'b1, 1'b0, 1'b1);
        at_period(base + 31, 8); chk("R1", 1'b1, 1'b0, 1'b1);
        at_period(base + 33, 8); chk("R2", 1'b1, 1'b0, 1'b1);
        at_period(base + 63, 8); chk("R2", 1'b1, 1'b0, 1'b1);
        at_period(base + 65, 8); chk("R2", 1'b0, 1'b0, 1'b0);
        at_period(base + 100, 8); chk("R6", 1'b0, 1'b0, 1'b0);

        // Short shutdown with over-temperature: released output, latch kept
        shutdown_in = 1'b1; over_temp = 1'b1;
        repeat (8) @(posedge clk);
        #1 chk("R8", 1'b0, 1'b0, 1'b1);
        repeat (100) @(posedge clk);
        #1 shutdown_in = 1'b0; over_temp = 1'b0;
        repeat (10) @(posedge clk);
        #1 chk("R9", 1'b0, 1'b0, 1'b0);

        // Long shutdown clears the latch and restarts
        long_shdn();
        chk("R8", 1'b0, 1'b0, 1'b1);
        shutdown_in = 1'b0;
        repeat (8) @(posedge clk);
        #1 chk("R9", 1'b1, 1'b0, 1'b1);

        // Pulse during start-up enters normal running
        at_phase(6); pulse();
        at_phase(12); chk("R3", 1'b0, 1'b1, 1'b1);
        over_temp = 1'b1;
        repeat (6) @(posedge clk);
        #1 chk("R10", 1'b0, 1'b1, 1'b0);
        over_temp = 1'b0;
        repeat (6) @(posedge clk);
        #1 chk("R10", 1'b0, 1'b1, 1'b1);

        // Shutdown in normal running, then restart burst
        shutdown_in = 1'b1;
        repeat (8) @(posedge clk);
        #1 chk("R8", 1'b0, 1'b0, 1'b1);
        shutdown_in = 1'b0;
        repeat (8) @(posedge clk);
        #1 chk("R8", 1'b1, 1'b0, 1'b1);

        // Watchdog restart by a pulse, then escalation table
        at_phase(6); k = tcnt / P; pulse();
        at_period(k + 20, 6); k = tcnt / P; pulse();
        for (int i = 0; i < 8; i++) begin
            at_period(k + TAB_N[i], 8);
            chk($sformatf("R%0d", TAB_R[i]), TAB_EXP[i][2], TAB_EXP[i][1], TAB_EXP[i][0]);
        end

        // Recovery from the diagnostic window and from the retry burst
        long_shdn();
        shutdown_in = 1'b0;
        at_phase(6); k = tcnt / P; pulse();
        at_period(k + 33, 5); chk("R4", 1'b1, 1'b0, 1'b1);
        at_period(k + 33, 6); k2 = tcnt / P; pulse();
        at_phase(12); chk("R4", 1'b0, 1'b1, 1'b1);
        at_period(k2 + 40, 6); k3 = tcnt / P; pulse();
        at_phase(12); chk("R5", 1'b0, 1'b1, 1'b1);

        // Pulses only inside the blanking window are ignored
        for (int i = 1; i <= 33; i++) begin
            at_period(k3 + i, 0);
            pulse();
        end
        at_period(k3 + 33, 8); chk("R7", 1'b1, 1'b0, 1'b1);
        at_phase(6); pulse();
        at_phase(12); chk("R7", 1'b0, 1'b1, 1'b1);

        // Sense held high counts once
        at_phase(6); k4 = tcnt / P; sense_in = 1'b1;
        at_period(k4 + 31, 8); chk("R11", 1'b0, 1'b1, 1'b1);
        at_period(k4 + 33, 8); chk("R11", 1'b1, 1'b0, 1'b1);
        sense_in = 1'b0;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule